// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This unit works next to a 32-bit integer adder/subtractor. From the two operands, an add or subtract select, a carry (or borrow) input and an operand-size select, it rebuilds the sum internally. It then derives six status bits: carry, overflow, sign, zero, auxiliary carry and parity. These bits are captured in a flags register on every clock edge where the update enable is high.

The operand size can be 8, 16 or 32 bits. Carry, overflow, sign and zero are judged at the selected width, and operand bits above that width have no effect on them. Auxiliary carry always looks at the carry or borrow between bit 3 and bit 4. Parity always looks at the lowest result byte, whatever the size.

Top module: `arith_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all six flags. The layout of `flags_q` is: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.
- R2: On a clock edge with `upd_en` low and reset low, `flags_q` keeps its previous value.
- R3: Carry (bit 0) is set on add when the unsigned sum exceeds the selected width, and on subtract when a borrow out of the selected width occurs.
- R4: Overflow (bit 5) is set when the signed result does not fit the selected width. On add this is when both operands share a sign and the result sign differs from it; on subtract the same test uses the inverted second operand.
- R5: Sign (bit 4) equals the most significant result bit at the selected width.
- R6: Zero (bit 3) is set exactly when all result bits at the selected width are zero.
- R7: Auxiliary carry (bit 2) is set on a carry from bit 3 into bit 4 on add, or on a borrow into bit 3 from bit 4 on subtract.
- R8: Parity (bit 1) is set when the lowest result byte holds an even number of ones, for every operand size.
- R9: `size_sel` encodes 0 as 8-bit, 1 as 16-bit, and 2 or 3 as 32-bit. Operand bits above the selected width do not affect carry, overflow, sign or zero.
- R10: With `op_sub` = 0 the result is opa + opb + carry_in. With `op_sub` = 1 it is opa - opb - carry_in, where carry_in acts as a borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| carry_in | input | 1 | Carry in on add, borrow in on subtract |
| size_sel | input | 2 | Operand size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| upd_en | input | 1 | Load the flags register on this edge |
| flags_q | output | 6 | Registered flags {ovf, sign, zero, aux, parity, carry} |

## Verification
The hardest cases to reach are the ones where a narrow size must ignore live upper bits while parity ignores the size altogether. An example is a 16-bit add whose result wraps to zero while opa carries nonzero upper bits, or whose low byte is zero while the sign bit is set. The vector table places such operands deliberately: upper-half garbage in the 8- and 16-bit entries, and a result of 0x8000 at 16 bits. Borrow-in on subtract and carry-in on add are each covered by entries whose result would differ by one without them.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

  localparam int FLAG_CNT = 6;

  // packed msb first: ovf is bit 5, cry is bit 0
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam flags_t FLAGS_CLEAR = '0;

  // width of size class k is 8 << k
  function automatic int size_width(input int k);
    return 8 << k;
  endfunction

endpackage

// File: rtl/aflag_adder.sv
module aflag_adder #(
  parameter int W   = 32,
  parameter int NSZ = 3
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sub,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic [NSZ-1:0] carry_hi,
  output logic [NSZ-1:0] carry_pre,
  output logic           nib_carry
);
  import aflag_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = sub ? ~b : b;
  assign c[0]  = sub ? ~cin : cin;

  // ripple structure; synthesis maps it onto carry chains
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
  end

  // tap the carries around the top bit of each operand size
  for (genvar k = 0; k < NSZ; k++) begin : g_tap
    localparam int TW = size_width(k);
    assign carry_hi[k]  = c[TW];
    assign carry_pre[k] = c[TW-1];
  end

  assign nib_carry = c[4];

endmodule

// File: rtl/aflag_eval.sv
module aflag_eval #(
  parameter int W    = 32,
  parameter int NSZ  = 3,
  parameter int SELW = 2
) (
  input  logic [W-1:0]    sum,
  input  logic [NSZ-1:0]  carry_hi,
  input  logic [NSZ-1:0]  carry_pre,
  input  logic            nib_carry,
  input  logic            sub,
  input  logic [SELW-1:0] size_sel,
  output aflag_pkg::flags_t flags
);
  import aflag_pkg::*;

  logic [NSZ-1:0] cf_v, of_v, sf_v, zf_v;
  logic [SELW-1:0] idx;

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int TW = size_width(k);
    // a borrow is the absence of carry in the inverted-operand sum
    assign cf_v[k] = carry_hi[k] ^ sub;
    // signed overflow: carry into the top bit differs from carry out of it
    assign of_v[k] = carry_hi[k] ^ carry_pre[k];
    assign sf_v[k] = sum[TW-1];
    assign zf_v[k] = ~|sum[TW-1:0];
  end

  always_comb begin
    if (int'(size_sel) >= NSZ) idx = SELW'(NSZ - 1);
    else                       idx = size_sel;
  end

  always_comb begin
    flags     = FLAGS_CLEAR;
    flags.cry = cf_v[idx];
    flags.ovf = of_v[idx];
    flags.sgn = sf_v[idx];
    flags.zer = zf_v[idx];
    flags.aux = nib_carry ^ sub;
    flags.par = ~^sum[7:0];
  end

endmodule

// File: rtl/aflag_reg.sv
module aflag_reg (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  aflag_pkg::flags_t d,
  output aflag_pkg::flags_t q
);
  import aflag_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)     q <= FLAGS_CLEAR;
    else if (en) q <= d;
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
  parameter int W    = 32,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic            op_sub,
  input  logic            carry_in,
  input  logic [SELW-1:0] size_sel,
  input  logic            upd_en,
  output logic [5:0]      flags_q
);
  import aflag_pkg::*;

  localparam int NSZ = $clog2(W / 8) + 1;

  logic [W-1:0]   sum;
  logic [NSZ-1:0] carry_hi, carry_pre;
  logic           nib_carry;
  flags_t         flags_d, flags_r;

  aflag_adder #(.W(W), .NSZ(NSZ)) adder_i (
    .a(opa), .b(opb), .sub(op_sub), .cin(carry_in),
    .sum(sum), .carry_hi(carry_hi), .carry_pre(carry_pre),
    .nib_carry(nib_carry)
  );

  aflag_eval #(.W(W), .NSZ(NSZ), .SELW(SELW)) eval_i (
    .sum(sum), .carry_hi(carry_hi), .carry_pre(carry_pre),
    .nib_carry(nib_carry), .sub(op_sub), .size_sel(size_sel),
    .flags(flags_d)
  );

  aflag_reg reg_i (
    .clk(clk), .rst(rst), .en(upd_en), .d(flags_d), .q(flags_r)
  );

  assign flags_q = flags_r;

endmodule

// File: rtl/aflag_checker.sv
module aflag_checker #(
  parameter int W    = 32,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    opa,
  input logic [W-1:0]    opb,
  input logic            op_sub,
  input logic            carry_in,
  input logic [SELW-1:0] size_sel,
  input logic            upd_en,
  input logic [5:0]      flags_q
);

  // R1: a reset edge leaves every flag clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags_q == 6'd0));

  // R2: no update, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags_q));

  // R5/R6: a zero result cannot carry a set sign bit
  assert_zero_not_neg_R6: assert property (@(posedge clk) disable iff (rst)
    flags_q[3] |-> !flags_q[4]);

  // R3/R4: adding zero with no carry-in neither carries nor overflows
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !op_sub && !carry_in && opb == '0) |=>
      (!flags_q[0] && !flags_q[5]));

  // R3/R7/R8: x - x with no borrow gives zero, even parity, no borrows
  assert_self_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_sub && !carry_in && opa == opb) |=>
      (flags_q == 6'b001010));

endmodule

bind arith_flag_unit aflag_checker #(.W(W), .SELW(SELW)) chk_i (
  .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sub(op_sub),
  .carry_in(carry_in), .size_sel(size_sel), .upd_en(upd_en),
  .flags_q(flags_q)
);

// File: tb/arith_flag_unit_tb_top.sv
`timescale 1ns/1ps
module arith_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opa, opb;
  logic        op_sub, carry_in, upd_en;
  logic [1:0]  size_sel;
  logic [5:0]  flags_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  arith_flag_unit dut_i (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sub(op_sub),
    .carry_in(carry_in), .size_sel(size_sel), .upd_en(upd_en),
    .flags_q(flags_q)
  );

  // {size, sub, cin, a, b, expected {ovf,sgn,zer,aux,par,cry}}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 32'h0000_007F, 32'h0000_0001, 6'b110100}, // R4 R5 R7
    {2'd0, 1'b0, 1'b0, 32'h0000_00FF, 32'h0000_0001, 6'b001111}, // R3 R6
    {2'd0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001, 6'b010111}, // R3 borrow
    {2'd0, 1'b1, 1'b0, 32'h0000_0080, 32'h0000_0001, 6'b100100}, // R4 sub
    {2'd1, 1'b0, 1'b0, 32'h1234_FFFF, 32'h0000_0001, 6'b001111}, // R9 upper ignored
    {2'd1, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_0001, 6'b110110}, // R8 low byte
    {2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 6'b001111}, // R10 carry-in
    {2'd2, 1'b1, 1'b1, 32'h0000_0005, 32'h0000_0003, 6'b000000}, // R10 borrow-in
    {2'd2, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0005, 6'b010101}, // R3 R7
    {2'd2, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 6'b101011}, // R4 neg+neg
    {2'd2, 1'b0, 1'b0, 32'h0F0F_0F0F, 32'h0000_0001, 6'b000100}, // R7 nibble
    {2'd3, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 6'b110110}, // R9 code 3
    {2'd0, 1'b1, 1'b0, 32'hABCD_0010, 32'h1234_0010, 6'b001010}, // R9 R6
    {2'd1, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_0001, 6'b100110}  // R4 R8
  };

  task automatic check(input string req, input logic [5:0] act,
                       input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] sz, input logic sb, input logic ci,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic en);
    @(negedge clk);
    size_sel = sz; op_sub = sb; carry_in = ci;
    opa = a; opb = b; upd_en = en;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; opa = '0; opb = '0; op_sub = 1'b0; carry_in = 1'b0;
    size_sel = 2'd0; upd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", flags_q, 6'b000000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][73:72], VEC[i][71], VEC[i][70],
            VEC[i][69:38], VEC[i][37:6], 1'b1);
      check($sformatf("R3-table entry %0d (R4 R5 R6 R7 R8 R9 R10)", i),
            flags_q, VEC[i][5:0]);
    end

    // R2: last entry left 100110; a zero-result subtract must not land
    apply(2'd2, 1'b1, 1'b0, 32'h55, 32'h55, 1'b0);
    check("R2 hold while disabled", flags_q, 6'b100110);
    apply(2'd0, 1'b0, 1'b0, 32'hFF, 32'h01, 1'b0);
    check("R2 hold second cycle", flags_q, 6'b100110);

    // R1: reset from a nonzero state, even with update requested
    @(negedge clk);
    rst = 1'b1; upd_en = 1'b1; size_sel = 2'd0;
    opa = 32'h7F; opb = 32'h01;
    @(negedge clk);
    check("R1 reset overrides update", flags_q, 6'b000000);
    rst = 1'b0;
    @(negedge clk);
    check("R5 update after reset release", flags_q, 6'b110100);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule